// File: doc/BRIEF.md
# Serial DAC Command Receiver

This block is the digital front end of a voltage-output DAC with a 14-bit code and a 2-bit power-down selector. It watches a three-wire serial input made of an active-low frame select, a serial clock and a serial data line. It oversamples all three in a much faster system clock domain. Each write is a 16-bit word sent MSB first. The word is assembled bit by bit, and on its last bit it is committed as a held DAC code and output mode.

If the frame select is released before the last bit, the partial word is discarded and nothing changes. Once a word has been committed, further serial clock edges are ignored until the select has gone high and then low again. The stored mode is decoded into one-hot controls for the output stage: amplifier on, 1 kΩ to ground, 100 kΩ to ground, or three-state. When the mode returns from any power-down state to normal, a ready flag stays low for a programmable settling time.

Top module: `dacrx_top`

## Requirements
- R1: After reset, the code is 0, the mode is 00 (normal), the mode-select output is 4'b0001, the ready flag is 1 and the update strobe is 0.
- R2: A frame starts when the select falls, and bits are taken on falling serial clock edges, MSB first. Frame bits 15:14 become the mode and bits 13:0 become the code. Both are committed on the 16th falling edge.
- R3: Each committed frame raises the update strobe for exactly one system clock, in the same cycle in which the new code and mode appear.
- R4: If the select rises before the 16th falling edge, the frame is dropped. Code, mode and strobe stay untouched, and the next frame is received from its first bit.
- R5: After a commit, further falling clock edges while the select stays low are ignored. No second strobe occurs and the code does not change.
- R6: Mode encoding 00/01/10/11 drives mode-select bit 0 (amplifier on), bit 1 (1 kΩ), bit 2 (100 kΩ) or bit 3 (three-state). Exactly one bit is set.
- R7: A commit that takes the mode from a non-zero value to 00 holds ready low for exactly WAKE_CYCLES system clocks from the strobe cycle. A commit from 00 to 00 leaves ready high.
- R8: While the mode is non-zero, ready is 0. Writing a power-down mode also loads the code field of the same frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rstN | input | 1 | Active-low asynchronous power-on reset |
| syncN | input | 1 | Active-low frame select from the serial master |
| sclk | input | 1 | Serial clock; data is taken on its falling edge |
| sdin | input | 1 | Serial data, MSB first |
| dacCode | output | 14 | Held DAC code |
| pdMode | output | 2 | Held output mode |
| modeSel | output | 4 | One-hot output-stage controls |
| updateStb | output | 1 | One-cycle pulse when a frame is committed |
| ready | output | 1 | High when in normal mode and settled |

## Verification
The bench builds the block with WAKE_CYCLES set to 20 instead of the default 650. This makes the settling window short enough to check its exact length: ready is sampled low on the last cycle of the window and high on the next. The serial clock runs at one eighth of the system clock, with four system clocks per phase. This leaves margin for the two-flop synchronizers while still giving exact strobe counts per frame. Code and frame widths stay at their defaults, so the abort, overrun and mode-decode scenarios use the full 16-bit word.

// File: rtl/dacrx_pkg.sv
package dacrx_pkg;
  typedef struct packed {
    logic shiftEn;
    logic clearShift;
    logic commit;
  } frameCtl_t;

  typedef enum logic [1:0] {
    ST_ARMED,
    ST_SHIFT,
    ST_DONE
  } frameSt_e;
endpackage

// File: rtl/dacrx_sync.sv
module dacrx_sync #(
  parameter int WIDTH = 3,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1  <= RESET_VAL;
      syncOut <= RESET_VAL;
    end else begin
      stage1  <= asyncIn;
      syncOut <= stage1;
    end
  end
endmodule

// File: rtl/dacrx_ctrl.sv
module dacrx_ctrl
  import dacrx_pkg::*;
#(
  parameter int FRAME_W = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      syncS,
  input  logic      sclkS,
  output frameCtl_t ctl
);
  localparam int CNT_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

  frameSt_e         state;
  logic [CNT_W-1:0] bitCnt;
  logic             sclkPrev;
  logic             sclkFall;

  assign sclkFall = sclkPrev & ~sclkS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sclkPrev <= 1'b1;
    else       sclkPrev <= sclkS;
  end

  always_comb begin
    ctl = '0;
    unique case (state)
      ST_ARMED: ctl.clearShift = ~syncS;
      ST_SHIFT: begin
        if (syncS) begin
          ctl.clearShift = 1'b1;
        end else if (sclkFall) begin
          ctl.shiftEn = 1'b1;
          ctl.commit  = (bitCnt == LAST_BIT);
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_DONE;
      bitCnt <= '0;
    end else begin
      unique case (state)
        ST_ARMED: if (!syncS) begin
          state  <= ST_SHIFT;
          bitCnt <= '0;
        end
        ST_SHIFT: begin
          if (syncS) begin
            state  <= ST_ARMED;
            bitCnt <= '0;
          end else if (sclkFall) begin
            if (bitCnt == LAST_BIT) state <= ST_DONE;
            else bitCnt <= bitCnt + 1'b1;
          end
        end
        default: if (syncS) state <= ST_ARMED;
      endcase
    end
  end
endmodule

// File: rtl/dacrx_datapath.sv
module dacrx_datapath
  import dacrx_pkg::*;
#(
  parameter int CODE_W      = 14,
  parameter int MODE_W      = 2,
  parameter int WAKE_CYCLES = 650
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  frameCtl_t                ctl,
  input  logic                     sdinBit,
  output logic [CODE_W-1:0]        dacCode,
  output logic [MODE_W-1:0]        pdMode,
  output logic [(1<<MODE_W)-1:0]   modeSel,
  output logic                     updateStb,
  output logic                     ready
);
  localparam int FRAME_W = CODE_W + MODE_W;
  localparam int SEL_W   = 1 << MODE_W;
  localparam int WAKE_W  = (WAKE_CYCLES < 1) ? 1 : $clog2(WAKE_CYCLES + 1);

  logic [FRAME_W-2:0] shiftReg;
  logic [FRAME_W-1:0] nextWord;
  logic [MODE_W-1:0]  newMode;
  logic [WAKE_W-1:0]  wakeCnt;

  assign nextWord = {shiftReg, sdinBit};
  assign newMode  = nextWord[FRAME_W-1 -: MODE_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               shiftReg <= '0;
    else if (ctl.clearShift) shiftReg <= '0;
    else if (ctl.shiftEn)    shiftReg <= nextWord[FRAME_W-2:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dacCode   <= '0;
      pdMode    <= '0;
      updateStb <= 1'b0;
      wakeCnt   <= '0;
    end else begin
      updateStb <= ctl.commit;
      if (ctl.commit) begin
        dacCode <= nextWord[CODE_W-1:0];
        pdMode  <= newMode;
      end
      if (ctl.commit && (pdMode != '0) && (newMode == '0))
        wakeCnt <= WAKE_W'(WAKE_CYCLES);
      else if (wakeCnt != '0)
        wakeCnt <= wakeCnt - 1'b1;
    end
  end

  assign ready = (pdMode == '0) && (wakeCnt == '0);

  for (genvar i = 0; i < SEL_W; i++) begin : g_sel
    assign modeSel[i] = (pdMode == MODE_W'(i));
  end
endmodule

// File: rtl/dacrx_top.sv
module dacrx_top
  import dacrx_pkg::*;
#(
  parameter int CODE_W      = 14,
  parameter int MODE_W      = 2,
  parameter int WAKE_CYCLES = 650
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   syncN,
  input  logic                   sclk,
  input  logic                   sdin,
  output logic [CODE_W-1:0]      dacCode,
  output logic [MODE_W-1:0]      pdMode,
  output logic [(1<<MODE_W)-1:0] modeSel,
  output logic                   updateStb,
  output logic                   ready
);
  localparam int FRAME_W = CODE_W + MODE_W;

  logic [2:0] pinsS;
  frameCtl_t  ctl;

  dacrx_sync #(.WIDTH(3), .RESET_VAL(3'b110)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({syncN, sclk, sdin}),
    .syncOut (pinsS)
  );

  dacrx_ctrl #(.FRAME_W(FRAME_W)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .syncS (pinsS[2]),
    .sclkS (pinsS[1]),
    .ctl   (ctl)
  );

  dacrx_datapath #(
    .CODE_W(CODE_W), .MODE_W(MODE_W), .WAKE_CYCLES(WAKE_CYCLES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .sdinBit   (pinsS[0]),
    .dacCode   (dacCode),
    .pdMode    (pdMode),
    .modeSel   (modeSel),
    .updateStb (updateStb),
    .ready     (ready)
  );
endmodule

// File: rtl/dacrx_chk.sv
module dacrx_chk #(
  parameter int CODE_W = 14,
  parameter int MODE_W = 2
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [CODE_W-1:0]      dacCode,
  input logic [MODE_W-1:0]      pdMode,
  input logic [(1<<MODE_W)-1:0] modeSel,
  input logic                   updateStb,
  input logic                   ready
);
  // R3
  stb_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    updateStb |=> !updateStb);

  // R4
  code_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dacCode) |-> updateStb);

  // R4
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(pdMode) |-> updateStb);

  // R6
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(modeSel) == 1);

  // R8
  pd_notready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pdMode != '0) |-> !ready);

  // R7
  wake_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (updateStb && ($past(pdMode) != '0) && (pdMode == '0)) |-> !ready);
endmodule

bind dacrx_top dacrx_chk #(.CODE_W(CODE_W), .MODE_W(MODE_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .dacCode   (dacCode),
  .pdMode    (pdMode),
  .modeSel   (modeSel),
  .updateStb (updateStb),
  .ready     (ready)
);

// File: tb/tb_dacrx_top.sv
`timescale 1ns/1ps
module tb_dacrx_top;
  localparam int WAKE = 20;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        syncN = 1'b1;
  logic        sclk = 1'b1;
  logic        sdin = 1'b0;
  logic [13:0] dacCode;
  logic [1:0]  pdMode;
  logic [3:0]  modeSel;
  logic        updateStb;
  logic        ready;

  int checks = 0;
  int failures = 0;
  int stbCount = 0;
  bit sawStb;

  always #10 clk = ~clk;

  dacrx_top #(.WAKE_CYCLES(WAKE)) dut (
    .clk(clk), .rstN(rstN), .syncN(syncN), .sclk(sclk), .sdin(sdin),
    .dacCode(dacCode), .pdMode(pdMode), .modeSel(modeSel),
    .updateStb(updateStb), .ready(ready)
  );

  always @(negedge clk) if (rstN && updateStb) stbCount++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Sends nbits of word MSB first, with an optional wake check at the commit.
  task automatic sendBits(input logic [31:0] word, input int nbits,
                          input bit wakeChk, input bit expReadyAtStb);
    sawStb = 0;
    @(negedge clk); syncN = 1'b0;
    idle(4);
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b1; sdin = word[nbits-1-i];
      idle(4);
      sclk = 1'b0;
      if (i == 15) begin
        for (int k = 0; k < 8 && !sawStb; k++) begin
          @(negedge clk);
          if (updateStb) sawStb = 1;
        end
        if (wakeChk) begin
          check("R7 ready at strobe", ready, expReadyAtStb);
          if (!expReadyAtStb) begin
            idle(WAKE - 1);
            check("R7 ready end of window", ready, 1'b0);
            idle(1);
            check("R7 ready after window", ready, 1'b1);
          end
        end
      end else begin
        idle(4);
      end
    end
    sclk = 1'b1;
    idle(4);
    syncN = 1'b1;
    idle(8);
  endtask

  task automatic testReset();
    check("R1 code", dacCode, 14'h0);
    check("R1 mode", pdMode, 2'b00);
    check("R1 sel", modeSel, 4'b0001);
    check("R1 ready", ready, 1'b1);
    check("R1 strobe", updateStb, 1'b0);
  endtask

  task automatic testNormalWrite();
    int s0 = stbCount;
    sendBits({16'h0, 2'b00, 14'h2A5C}, 16, 1'b1, 1'b1);
    check("R2 code", dacCode, 14'h2A5C);
    check("R2 mode", pdMode, 2'b00);
    check("R3 one strobe", stbCount - s0, 1);
    check("R6 sel normal", modeSel, 4'b0001);
  endtask

  task automatic testModes();
    sendBits({16'h0, 2'b01, 14'h0123}, 16, 1'b0, 1'b0);
    check("R8 code with pd1", dacCode, 14'h0123);
    check("R6 sel 1k", modeSel, 4'b0010);
    check("R8 ready pd1", ready, 1'b0);
    sendBits({16'h0, 2'b10, 14'h3FFF}, 16, 1'b0, 1'b0);
    check("R2 mode 10", pdMode, 2'b10);
    check("R6 sel 100k", modeSel, 4'b0100);
    sendBits({16'h0, 2'b11, 14'h1555}, 16, 1'b0, 1'b0);
    check("R6 sel tristate", modeSel, 4'b1000);
    check("R8 ready pd3", ready, 1'b0);
    check("R8 code pd3", dacCode, 14'h1555);
  endtask

  task automatic testWake();
    sendBits({16'h0, 2'b00, 14'h1000}, 16, 1'b1, 1'b0);
    check("R7 code after wake", dacCode, 14'h1000);
    sendBits({16'h0, 2'b00, 14'h1001}, 16, 1'b1, 1'b1);
  endtask

  task automatic testAbort();
    int s0 = stbCount;
    sendBits({23'h0, 9'h1FF}, 9, 1'b0, 1'b0);
    check("R4 code kept", dacCode, 14'h1001);
    check("R4 mode kept", pdMode, 2'b00);
    check("R4 no strobe", stbCount - s0, 0);
    sendBits({16'h0, 2'b00, 14'h0001}, 16, 1'b0, 1'b0);
    check("R4 next frame", dacCode, 14'h0001);
  endtask

  task automatic testOverrun();
    int s0 = stbCount;
    sendBits({8'h0, 2'b00, 14'h0ABC, 8'hFF}, 24, 1'b0, 1'b0);
    check("R5 code first 16", dacCode, 14'h0ABC);
    check("R5 mode", pdMode, 2'b00);
    check("R5 one strobe", stbCount - s0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle(5);
    rstN = 1'b1;
    idle(4);
    testReset();
    testNormalWrite();
    testModes();
    testWake();
    testAbort();
    testOverrun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule